// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Controller

This block sits behind the byte layer of an I2C target and handles direct user-memory reads and writes of a paged nonvolatile array. The array is modelled as an inferred RAM with a fixed programming time. The byte layer supplies start and stop events, received bytes and read requests. In return the block gives an acknowledge decision for each byte, read data, an 8-bit status word and a one-byte return code.

A write sends the device address with the direction bit at 0, then two address bytes (high byte first), then data. The data stays in a page-sized holding buffer. It is committed only when a stop condition closes the transaction, and only if the target is writable and the data fits inside one page. A rejected write is dropped and reported through the status word and the return code. While programming runs, every device address byte is refused. Reads return sequential bytes from the last address pair. A byte at an invalid or prohibited location comes back as 0xFF and raises the error flag.

Top module: `eewc_top`

## Requirements
- R1: After reset, status_o is 0x00, rcode_o is 0x00, and ack_valid_o and rd_valid_o are 0.
- R2: For every received byte, ack_valid_o pulses one cycle later. The first byte after a start is acknowledged only when bits 7:1 equal DEV_ADDR and the block is idle. Bit 0 selects read (1) or write (0). After a refused device byte, every further byte of that transaction is refused.
- R3: Write data is committed only on a stop. A start that arrives before the stop discards the buffered bytes: memory, status_o and rcode_o stay unchanged, and the pointer keeps the address just sent.
- R4: An accepted write holds status bit 0 (busy) at 1 for exactly PROG_CYCLES cycles, starting in the cycle after the stop. It sets bit 6 (response ready) to 1, bit 7 (error) to 0 and rcode_o to 0x00. Afterwards the written bytes read back.
- R5: While status bit 0 is 1, any device address byte is refused, even a matching one.
- R6: A write whose start address is beyond MEM_BYTES, inside the write-protected window [WP_LO,WP_HI) or inside the secret window [SEC_LO,SEC_HI) is rejected with rcode_o 0x04. This check takes priority over the page check.
- R7: A write whose page offset plus byte count exceeds PAGE_BYTES (32) is rejected with rcode_o 0x02. An exact fit to the page end is accepted.
- R8: Data bytes beyond PAGE_BYTES are still acknowledged but dropped, and the write is rejected with rcode_o 0x02.
- R9: A rejected write never programs: busy stays 0, memory is unchanged, bit 6 becomes 1 and bit 7 becomes 1.
- R10: Each read request in a read transaction returns one byte, with rd_valid_o one cycle later, from the pointer, which then increments. Reads leave bit 6 and rcode_o unchanged.
- R11: A read byte at an address at or beyond MEM_BYTES, or inside the secret window, returns 0xFF and sets bit 7. Bit 7 is cleared when a read device address is acknowledged.
- R12: Status bits 5:1 always read 0.
- R13: A stop after the address bytes with no data sets only the pointer. Status and return code do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or repeated-start event |
| stop_i | input | 1 | Stop event |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Host requests one read byte |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NAK |
| rd_valid_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |
| status_o | output | 8 | Status word |
| rcode_o | output | 8 | Return code of last write |

## Verification
On every cycle, the assertions check that each acknowledge decision follows a received byte, and that a device byte arriving during programming is refused. They also check that programming starts only from an accepted stop commit and ends only after all buffered bytes are written, that a rejected commit leaves the programmer idle, and that reads keep the response flag and return code steady while flagging bad bytes. Other behaviour needs the bench's scenarios and its reference model: data that survives a repeated start, access and page priorities, overflow handling, exact busy duration, and read wrap into prohibited areas.

// File: rtl/eewc_pkg.sv
package eewc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_AHI, S_ALO, S_DATA, S_READ, S_SKIP
  } fe_state_t;

  localparam logic [7:0] RC_OK       = 8'h00;
  localparam logic [7:0] RC_BOUNDARY = 8'h02;
  localparam logic [7:0] RC_ACCESS   = 8'h04;
endpackage

// File: rtl/eewc_array.sv
module eewc_array #(
  parameter int unsigned MEM_BYTES = 512,
  localparam int unsigned MEM_AW = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [MEM_AW-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic              re_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/eewc_policy.sv
module eewc_policy
  import eewc_pkg::*;
#(
  parameter int unsigned MEM_BYTES  = 512,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned WP_LO      = 256,
  parameter int unsigned WP_HI      = 384,
  parameter int unsigned SEC_LO     = 384,
  parameter int unsigned SEC_HI     = 512,
  localparam int unsigned PG_AW = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W = PG_AW + 1
) (
  input  logic [15:0]      wr_addr_i,
  input  logic [CNT_W-1:0] wr_len_i,
  input  logic             wr_ovf_i,
  input  logic [15:0]      rd_addr_i,
  output logic [7:0]       rc_o,
  output logic             rd_bad_o
);
  logic [31:0] wa, ra;
  logic [PG_AW+1:0] span;
  logic wr_denied, wr_spills;

  always_comb begin
    wa = {16'b0, wr_addr_i};
    ra = {16'b0, rd_addr_i};
    wr_denied = (wa >= MEM_BYTES) || (wa >= WP_LO && wa < WP_HI) ||
                (wa >= SEC_LO && wa < SEC_HI);
    span = (PG_AW+2)'(wr_addr_i[PG_AW-1:0]) + (PG_AW+2)'(wr_len_i);
    wr_spills = wr_ovf_i || (span > (PG_AW+2)'(PAGE_BYTES));
    if (wr_denied)      rc_o = RC_ACCESS;
    else if (wr_spills) rc_o = RC_BOUNDARY;
    else                rc_o = RC_OK;
    rd_bad_o = (ra >= MEM_BYTES) || (ra >= SEC_LO && ra < SEC_HI);
  end
endmodule

// File: rtl/eewc_frontend.sv
module eewc_frontend
  import eewc_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR   = 7'h50,
  parameter int unsigned PAGE_BYTES = 32,
  localparam int unsigned PG_AW = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W = PG_AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             rd_req_i,
  input  logic             busy_i,
  output logic             ack_valid_o,
  output logic             ack_o,
  output logic             commit_o,
  output logic [15:0]      ptr_o,
  output logic [CNT_W-1:0] len_o,
  output logic             ovf_o,
  output logic             rd_en_o,
  output logic             rd_open_o,
  input  logic [PG_AW-1:0] buf_idx_i,
  output logic [7:0]       buf_data_o
);
  fe_state_t state;
  logic [7:0] addr_hi;
  logic [7:0] wbuf [PAGE_BYTES];
  logic byte_ev, dev_hit, full;

  always_comb begin
    byte_ev    = rx_valid_i && !start_i && !stop_i;
    dev_hit    = (rx_byte_i[7:1] == DEV_ADDR) && !busy_i;
    full       = (len_o == CNT_W'(PAGE_BYTES));
    commit_o   = stop_i && !start_i && (state == S_DATA) && (len_o != '0 || ovf_o);
    rd_open_o  = byte_ev && (state == S_DEV) && dev_hit && rx_byte_i[0];
    rd_en_o    = rd_req_i && !start_i && !stop_i && !rx_valid_i && (state == S_READ);
    buf_data_o = wbuf[buf_idx_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; ack_valid_o <= 1'b0; ack_o <= 1'b0;
      ptr_o <= '0; addr_hi <= '0; len_o <= '0; ovf_o <= 1'b0;
    end else begin
      ack_valid_o <= 1'b0;
      if (start_i) begin
        state <= S_DEV;
      end else if (stop_i) begin
        state <= S_IDLE; len_o <= '0; ovf_o <= 1'b0;
      end else if (rx_valid_i) begin
        ack_valid_o <= 1'b1;
        ack_o <= 1'b0;
        case (state)
          S_DEV: begin
            if (dev_hit) begin
              ack_o <= 1'b1;
              state <= rx_byte_i[0] ? S_READ : S_AHI;
            end else begin
              state <= S_SKIP;
            end
          end
          S_AHI: begin addr_hi <= rx_byte_i; ack_o <= 1'b1; state <= S_ALO; end
          S_ALO: begin
            ptr_o <= {addr_hi, rx_byte_i}; len_o <= '0; ovf_o <= 1'b0;
            ack_o <= 1'b1; state <= S_DATA;
          end
          S_DATA: begin
            ack_o <= 1'b1;
            if (!full) len_o <= len_o + 1'b1;
            else       ovf_o <= 1'b1;
          end
          default: ;
        endcase
      end else if (rd_en_o) begin
        ptr_o <= ptr_o + 16'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_ev && state == S_DATA && !full) wbuf[len_o[PG_AW-1:0]] <= rx_byte_i;
  end

  a_r2_ack_follows_byte: assert property (@(posedge clk) disable iff (rst)
    ack_valid_o |-> $past(rx_valid_i));
  a_r5_busy_nak: assert property (@(posedge clk) disable iff (rst)
    (byte_ev && state == S_DEV && busy_i) |=> (ack_valid_o && !ack_o));
endmodule

// File: rtl/eewc_prog.sv
module eewc_prog #(
  parameter int unsigned MEM_BYTES   = 512,
  parameter int unsigned PAGE_BYTES  = 32,
  parameter int unsigned PROG_CYCLES = 40,
  localparam int unsigned MEM_AW = $clog2(MEM_BYTES),
  localparam int unsigned PG_AW  = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W  = PG_AW + 1,
  localparam int unsigned PC_W   = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic              pass_i,
  input  logic [MEM_AW-1:0] base_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              busy_o,
  output logic [PG_AW-1:0]  buf_idx_o,
  output logic              we_o,
  output logic [MEM_AW-1:0] waddr_o
);
  logic [PC_W-1:0]   pc;
  logic [CNT_W-1:0]  idx, len_q;
  logic [MEM_AW-1:0] base_q;

  always_comb begin
    we_o      = busy_o && (idx < len_q);
    buf_idx_o = idx[PG_AW-1:0];
    waddr_o   = base_q + MEM_AW'(idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0; pc <= '0; idx <= '0; len_q <= '0; base_q <= '0;
    end else if (commit_i && pass_i && !busy_o) begin
      busy_o <= 1'b1;
      pc     <= PC_W'(PROG_CYCLES - 1);
      idx    <= '0;
      len_q  <= len_i;
      base_q <= base_i;
    end else if (busy_o) begin
      if (we_o) idx <= idx + 1'b1;
      if (pc == '0) busy_o <= 1'b0;
      else          pc <= pc - 1'b1;
    end
  end

  a_r3_busy_from_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(commit_i && pass_i));
  a_r9_reject_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !pass_i && !busy_o) |=> !busy_o);
  a_r4_all_bytes_written: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(idx) == $past(len_q)));
endmodule

// File: rtl/eewc_top.sv
module eewc_top
  import eewc_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned MEM_BYTES   = 512,
  parameter int unsigned PAGE_BYTES  = 32,
  parameter int unsigned PROG_CYCLES = 40,
  parameter int unsigned WP_LO       = 256,
  parameter int unsigned WP_HI       = 384,
  parameter int unsigned SEC_LO      = 384,
  parameter int unsigned SEC_HI      = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  input  logic       rd_req_i,
  output logic       ack_valid_o,
  output logic       ack_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic [7:0] status_o,
  output logic [7:0] rcode_o
);
  localparam int unsigned MEM_AW = $clog2(MEM_BYTES);
  localparam int unsigned PG_AW  = $clog2(PAGE_BYTES);
  localparam int unsigned CNT_W  = PG_AW + 1;

  logic busy, commit, ovf, rd_en, rd_open, rd_bad, we, inv_q, rrdy, eerr;
  logic [15:0] ptr;
  logic [CNT_W-1:0] len;
  logic [PG_AW-1:0] buf_idx;
  logic [7:0] buf_data, rc_w, mem_q;
  logic [MEM_AW-1:0] waddr;

  eewc_frontend #(.DEV_ADDR(DEV_ADDR), .PAGE_BYTES(PAGE_BYTES)) u_fe (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .rd_req_i(rd_req_i),
    .busy_i(busy), .ack_valid_o(ack_valid_o), .ack_o(ack_o),
    .commit_o(commit), .ptr_o(ptr), .len_o(len), .ovf_o(ovf),
    .rd_en_o(rd_en), .rd_open_o(rd_open),
    .buf_idx_i(buf_idx), .buf_data_o(buf_data));

  eewc_policy #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
                .WP_LO(WP_LO), .WP_HI(WP_HI), .SEC_LO(SEC_LO), .SEC_HI(SEC_HI)) u_pol (
    .wr_addr_i(ptr), .wr_len_i(len), .wr_ovf_i(ovf), .rd_addr_i(ptr),
    .rc_o(rc_w), .rd_bad_o(rd_bad));

  eewc_prog #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
              .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .commit_i(commit), .pass_i(rc_w == RC_OK),
    .base_i(ptr[MEM_AW-1:0]), .len_i(len), .busy_o(busy),
    .buf_idx_o(buf_idx), .we_o(we), .waddr_o(waddr));

  eewc_array #(.MEM_BYTES(MEM_BYTES)) u_mem (
    .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i(buf_data),
    .re_i(rd_en), .raddr_i(ptr[MEM_AW-1:0]), .rdata_o(mem_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      rrdy <= 1'b0; eerr <= 1'b0; rcode_o <= RC_OK;
      rd_valid_o <= 1'b0; inv_q <= 1'b0;
    end else begin
      rd_valid_o <= rd_en;
      if (rd_en) inv_q <= rd_bad;
      if (commit && !busy) begin
        rrdy <= 1'b1;
        eerr <= (rc_w != RC_OK);
        rcode_o <= rc_w;
      end else if (rd_open) begin
        eerr <= 1'b0;
      end else if (rd_en && rd_bad) begin
        eerr <= 1'b1;
      end
    end
  end

  assign rd_data_o = inv_q ? 8'hFF : mem_q;
  // bit7 error, bit6 response ready, bits 5:1 fixed zero (R12), bit0 busy
  assign status_o  = {eerr, rrdy, 5'b00000, busy};

  a_r10_read_keeps_response: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> ($stable(rcode_o) && $stable(status_o[6])));
  a_r11_bad_byte_flags_error: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && inv_q) |-> status_o[7]);
endmodule

// File: tb/test_eewc_top.sv
`timescale 1ns/1ps
module test_eewc_top;
  localparam int MEM = 512, PG = 32, PROG = 40;
  localparam int WPL = 256, WPH = 384, SL = 384, SH = 512;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, stop_i = 0, rx_valid_i = 0, rd_req_i = 0;
  logic [7:0] rx_byte_i = 0;
  logic ack_valid_o, ack_o, rd_valid_o;
  logic [7:0] rd_data_o, status_o, rcode_o;

  always #10 clk = ~clk;

  eewc_top i_eewc_top (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .rd_req_i(rd_req_i),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .status_o(status_o), .rcode_o(rcode_o));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur = "R1";

  // reference model state
  int st, hi, ptr, left, ovf;
  byte unsigned bq[$];
  logic [7:0] mmem [0:MEM-1];
  logic e_ackv, e_ack, e_rdv, e_rrdy, e_eerr;
  logic [7:0] e_rdd, e_rc;

  task automatic chk(string tag, string what, logic [7:0] a, logic [7:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, a, e, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      st = 0; hi = 0; ptr = 0; left = 0; ovf = 0; bq.delete();
      e_ackv = 0; e_ack = 0; e_rdv = 0; e_rdd = 0; e_rrdy = 0; e_eerr = 0; e_rc = 0;
    end else begin
      automatic bit busy_old = (left > 0);
      if (left > 0) left--;
      e_ackv = 0; e_rdv = 0;
      if (start_i) st = 1;
      else if (stop_i) begin
        if (st == 4 && (bq.size() > 0 || ovf)) begin
          automatic int code;
          if (ptr >= MEM || (ptr >= WPL && ptr < WPH) || (ptr >= SL && ptr < SH)) code = 4;
          else if (ovf || (ptr % PG) + bq.size() > PG) code = 2;
          else code = 0;
          e_rrdy = 1; e_eerr = (code != 0); e_rc = code[7:0];
          if (code == 0) begin
            foreach (bq[i]) mmem[ptr + i] = bq[i];
            left = PROG;
          end
        end
        bq.delete(); ovf = 0; st = 0;
      end else if (rx_valid_i) begin
        e_ackv = 1; e_ack = 0;
        case (st)
          1: if (rx_byte_i[7:1] == 7'h50 && !busy_old) begin
               e_ack = 1;
               if (rx_byte_i[0]) begin st = 5; e_eerr = 0; end else st = 2;
             end else st = 6;
          2: begin hi = rx_byte_i; e_ack = 1; st = 3; end
          3: begin ptr = hi * 256 + rx_byte_i; e_ack = 1; st = 4; bq.delete(); ovf = 0; end
          4: begin e_ack = 1; if (bq.size() < PG) bq.push_back(rx_byte_i); else ovf = 1; end
          default: ;
        endcase
      end else if (rd_req_i && st == 5) begin
        automatic bit bad = (ptr >= MEM) || (ptr >= SL && ptr < SH);
        e_rdv = 1;
        e_rdd = bad ? 8'hFF : mmem[ptr];
        if (bad) e_eerr = 1;
        ptr = (ptr + 1) % 65536;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur, "ack_valid", {7'b0, ack_valid_o}, {7'b0, e_ackv});
      if (e_ackv) chk(cur, "ack", {7'b0, ack_o}, {7'b0, e_ack});
      chk(cur, "rd_valid", {7'b0, rd_valid_o}, {7'b0, e_rdv});
      if (e_rdv) chk(cur, "rd_data", rd_data_o, e_rdd);
      chk(cur, "status", status_o, {e_eerr, e_rrdy, 5'b0, left > 0});
      chk(cur, "rcode", rcode_o, e_rc);
    end
  end

  task automatic ev(int kind, logic [7:0] b = 8'h00);
    @(negedge clk);
    case (kind)
      0: start_i = 1;
      1: stop_i = 1;
      2: begin rx_valid_i = 1; rx_byte_i = b; end
      default: rd_req_i = 1;
    endcase
    @(negedge clk);
    start_i = 0; stop_i = 0; rx_valid_i = 0; rd_req_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int n, int v, bit stop = 1);
    ev(0); ev(2, 8'hA0); ev(2, a[15:8]); ev(2, a[7:0]);
    for (int i = 0; i < n; i++) ev(2, 8'(v + i));
    if (stop) ev(1);
  endtask

  task automatic rd(int a, int n);
    ev(0); ev(2, 8'hA0); ev(2, a[15:8]); ev(2, a[7:0]);
    ev(0); ev(2, 8'hA1);
    for (int i = 0; i < n; i++) ev(3);
    ev(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3); @(negedge clk); rst = 0;
    cur = "R1"; idle(4);
    chk("R1", "reset status", status_o, 8'h00);
    cur = "R4"; wr(16'h0010, 4, 8'h31); idle(PROG + 4); rd(16'h0010, 4);
    cur = "R5"; wr(16'h0020, 2, 8'h55); ev(0); ev(2, 8'hA0); ev(2, 8'h00); ev(1);
    idle(PROG + 4); rd(16'h0020, 2);
    cur = "R2"; ev(0); ev(2, 8'hA2); ev(2, 8'h00); ev(2, 8'h10); ev(2, 8'h99); ev(1);
    rd(16'h0010, 1);
    cur = "R3"; wr(16'h0010, 3, 8'hE0, 0); rd(16'h0010, 4);
    cur = "R6"; wr(16'h0100, 1, 8'h01); wr(16'h0200, 1, 8'h02);
    wr(16'h0180, 1, 8'h03); wr(16'h011E, 8, 8'h04);
    cur = "R7"; wr(16'h001C, 8, 8'h70);
    cur = "R9"; rd(16'h0010, 4);
    cur = "R7"; wr(16'h001C, 4, 8'h80); idle(PROG + 4); rd(16'h001C, 4);
    cur = "R8"; wr(16'h0060, 33, 8'h00); rd(16'h0010, 2);
    wr(16'h0060, 32, 8'h40); idle(PROG + 4); rd(16'h0060, 32);
    cur = "R13"; wr(16'h007E, 0, 0); idle(4);
    cur = "R10"; rd(16'h007E, 4);
    cur = "R11"; rd(16'h01FE, 4); rd(16'h017E, 0); rd(16'hFFFF, 2); rd(16'h0060, 1);
    cur = "R12"; idle(2);
    chk("R12", "reserved bits", status_o & 8'h3E, 8'h00);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule